// File: doc/BRIEF.md
# ATA Channel Software Reset Sequencer

This block is a host-side controller that takes a parallel ATA channel through a software reset on request. After a `start` pulse it waits a settling delay, so that a drive still recovering from a hardware reset is left alone. It then reads the status register until the busy flag drops. Next it sets the soft-reset bit in the device control register, holds it for a short interval and clears it again. After a second settling delay it polls busy once more. It finishes with a one-cycle `done`, or with a one-cycle `err` if busy stays high past the timeout in either polling phase. Interrupts stay masked in every value it writes.

Register accesses leave through a simple strobe port. `bus_rd` or `bus_wr` selects the command block or the control block and a 3-bit offset. Read data is expected on `bus_rdata` in the cycle after the read strobe. Every delay is counted in ticks of a prescaler that divides the clock by `TICK_DIV`. The prescaler restarts whenever a delay is loaded. The settle, hold and timeout lengths are parameters given in ticks: the defaults model about 2 ms, 5 µs and 32 s with a 1 µs tick. Simulation can use short values.

Top module: `ata_srst_seq`

## Requirements
- R1: While reset is applied and afterwards until `start`, the block is idle: `done`, `err`, `bus_rd` and `bus_wr` are all low.
- R2: After an accepted `start`, no register access occurs for at least SETTLE_TICKS*TICK_DIV clock cycles. The first status read comes no more than 4 cycles after that.
- R3: Every read targets the command block (`bus_ctl_blk`=0) at offset 7 (status). No write happens while the last status read returned bit 7 (busy) as 1.
- R4: The reset-assert write goes to the control block (`bus_ctl_blk`=1) at offset 2 with value 0x0E. In that value bit 3 is always set, bit 2 is the soft-reset bit and bit 1 masks interrupts. Only the values 0x0E and 0x0A are ever written, only to that register.
- R5: Between HOLD_TICKS*TICK_DIV and HOLD_TICKS*TICK_DIV+4 cycles after the assert write, the block writes 0x0A to the same register. This clears soft reset and keeps interrupts masked.
- R6: After the release write the block waits at least SETTLE_TICKS*TICK_DIV cycles and then polls status again. The first such read comes within 4 cycles of that point. `done` pulses once busy reads 0.
- R7: If busy stays 1 for TIMEOUT_TICKS ticks in either polling phase, `err` pulses. No further write follows, and the block returns to idle ready for a new `start`.
- R8: A `start` that arrives while a sequence is running is ignored. It neither restarts the timing nor causes extra accesses or pulses.
- R9: `done` and `err` are single-cycle pulses, never high together, and exactly one of them ends each sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a reset sequence (accepted only when idle) |
| done | output | 1 | One-cycle pulse: sequence completed, device not busy |
| err | output | 1 | One-cycle pulse: busy did not clear within the timeout |
| bus_rd | output | 1 | Register read strobe |
| bus_wr | output | 1 | Register write strobe |
| bus_ctl_blk | output | 1 | 1 = control block, 0 = command block |
| bus_addr | output | 3 | Register offset within the selected block |
| bus_wdata | output | 8 | Write data |
| bus_rdata | input | 8 | Read data, valid the cycle after `bus_rd` |

## Verification
The sequence is tried against a device model whose busy flag is clear throughout, busy only before the reset pulse, busy only after it, or stuck busy on either side. Each pattern isolates one wait: the pre-reset poll, the post-reset poll, or the timeout path with its suppression of writes. The gaps between start, the two writes and the first post-release read are measured against tick-derived bounds. These bounds separate a missing or shortened delay from a correct one. A run with extra `start` pulses during settle and hold shows that the timing and the access count stay those of a single sequence.

// File: rtl/ata_srst_pkg.sv
// Package: shared types and constants for the ATA software reset sequencer.
// Assumes register offsets and device-control values of a standard ATA channel.
package ata_srst_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SETTLE_PRE,
        ST_POLL_PRE_RD,
        ST_POLL_PRE_CHK,
        ST_SRST_ON,
        ST_SRST_HOLD,
        ST_SRST_OFF,
        ST_SETTLE_POST,
        ST_POLL_POST_RD,
        ST_POLL_POST_CHK,
        ST_FINISH,
        ST_ABORT
    } seq_state_e;

    localparam logic [2:0] STATUS_OFS      = 3'd7;
    localparam logic [2:0] DEVCTL_OFS      = 3'd2;
    localparam logic [7:0] DEVCTL_SRST_ON  = 8'h0E;
    localparam logic [7:0] DEVCTL_SRST_OFF = 8'h0A;
    localparam int         BSY_BIT         = 7;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/ata_srst_tick.sv
// Module: tick prescaler. Emits one tick every TICK_DIV clocks.
// Assumes clr restarts the phase so a freshly loaded delay is exact.
module ata_srst_tick #(
    parameter int TICK_DIV = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick
);

    if (TICK_DIV > 1) begin : g_div
        localparam int PW = $clog2(TICK_DIV);
        localparam logic [PW-1:0] LAST = PW'(TICK_DIV - 1);
        logic [PW-1:0] pcnt;

        // Purpose: count clocks within one tick period.
        always_ff @(posedge clk) begin
            if (!rst_n || clr)   pcnt <= '0;
            else if (pcnt == LAST) pcnt <= '0;
            else                 pcnt <= pcnt + 1'b1;
        end

        assign tick = (pcnt == LAST);

        AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
            tick |=> !tick);  // R2
    end else begin : g_nodiv
        assign tick = 1'b1;
    end

endmodule

// File: rtl/ata_srst_timer.sv
// Module: down-counting delay timer in ticks.
// Assumes load has priority; expired is high while the count is zero.
module ata_srst_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] val,
    input  logic          tick,
    output logic          expired
);

    logic [TW-1:0] cnt;

    // Purpose: load a delay, then step it down once per tick to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)                  cnt <= '0;
        else if (load)               cnt <= val;
        else if (tick && cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);

    AST_EXP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (expired && !load) |=> expired);  // R2

endmodule

// File: rtl/ata_srst_fsm.sv
// Module: sequencing state machine for the software reset.
// Assumes read data arrives the cycle after bus_rd, and that the timer
// reports expiry the cycle after its loaded count reaches zero.
module ata_srst_fsm
    import ata_srst_pkg::*;
#(
    parameter int TW            = 8,
    parameter int SETTLE_TICKS  = 2000,
    parameter int HOLD_TICKS    = 5,
    parameter int TIMEOUT_TICKS = 32_000_000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          busy_bit,
    input  logic          tmr_exp,
    output logic          tmr_load,
    output logic [TW-1:0] tmr_val,
    output logic          bus_rd,
    output logic          bus_wr,
    output logic          bus_ctl_blk,
    output logic [2:0]    bus_addr,
    output logic [7:0]    bus_wdata,
    output logic          done,
    output logic          err
);

    localparam logic [TW-1:0] SETTLE_V  = TW'(SETTLE_TICKS);
    localparam logic [TW-1:0] HOLD_V    = TW'(HOLD_TICKS);
    localparam logic [TW-1:0] TIMEOUT_V = TW'(TIMEOUT_TICKS);

    seq_state_e state, state_nx;

    // Purpose: hold the current sequencing step.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Purpose: choose the next step, the timer load and the bus access.
    always_comb begin
        state_nx    = state;
        tmr_load    = 1'b0;
        tmr_val     = SETTLE_V;
        bus_rd      = 1'b0;
        bus_wr      = 1'b0;
        bus_ctl_blk = 1'b0;
        bus_addr    = STATUS_OFS;
        bus_wdata   = DEVCTL_SRST_OFF;
        done        = 1'b0;
        err         = 1'b0;
        unique case (state)
            ST_IDLE: if (start) begin
                tmr_load = 1'b1;
                tmr_val  = SETTLE_V;
                state_nx = ST_SETTLE_PRE;
            end
            ST_SETTLE_PRE: if (tmr_exp) begin
                tmr_load = 1'b1;
                tmr_val  = TIMEOUT_V;
                state_nx = ST_POLL_PRE_RD;
            end
            ST_POLL_PRE_RD: begin
                bus_rd   = 1'b1;
                state_nx = ST_POLL_PRE_CHK;
            end
            ST_POLL_PRE_CHK: begin
                if (!busy_bit)    state_nx = ST_SRST_ON;
                else if (tmr_exp) state_nx = ST_ABORT;
                else              state_nx = ST_POLL_PRE_RD;
            end
            ST_SRST_ON: begin
                bus_wr      = 1'b1;
                bus_ctl_blk = 1'b1;
                bus_addr    = DEVCTL_OFS;
                bus_wdata   = DEVCTL_SRST_ON;
                tmr_load    = 1'b1;
                tmr_val     = HOLD_V;
                state_nx    = ST_SRST_HOLD;
            end
            ST_SRST_HOLD: if (tmr_exp) state_nx = ST_SRST_OFF;
            ST_SRST_OFF: begin
                bus_wr      = 1'b1;
                bus_ctl_blk = 1'b1;
                bus_addr    = DEVCTL_OFS;
                bus_wdata   = DEVCTL_SRST_OFF;
                tmr_load    = 1'b1;
                tmr_val     = SETTLE_V;
                state_nx    = ST_SETTLE_POST;
            end
            ST_SETTLE_POST: if (tmr_exp) begin
                tmr_load = 1'b1;
                tmr_val  = TIMEOUT_V;
                state_nx = ST_POLL_POST_RD;
            end
            ST_POLL_POST_RD: begin
                bus_rd   = 1'b1;
                state_nx = ST_POLL_POST_CHK;
            end
            ST_POLL_POST_CHK: begin
                if (!busy_bit)    state_nx = ST_FINISH;
                else if (tmr_exp) state_nx = ST_ABORT;
                else              state_nx = ST_POLL_POST_RD;
            end
            ST_FINISH: begin
                done     = 1'b1;
                state_nx = ST_IDLE;
            end
            ST_ABORT: begin
                err      = 1'b1;
                state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    AST_READ_STATUS_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |-> (!bus_ctl_blk && bus_addr == STATUS_OFS && !bus_wr));  // R3
    AST_WRITE_DEVCTL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr |-> (bus_ctl_blk && bus_addr == DEVCTL_OFS &&
                    (bus_wdata == DEVCTL_SRST_ON || bus_wdata == DEVCTL_SRST_OFF)));  // R4
    AST_RELEASE_AFTER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_wdata == DEVCTL_SRST_ON) |=> (state == ST_SRST_HOLD));  // R5
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);  // R9
    AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> !err);  // R9
    AST_END_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && err));  // R9
    AST_NO_WRITE_AFTER_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> !bus_wr);  // R7

endmodule

// File: rtl/ata_srst_seq.sv
// Module: top of the ATA software reset sequencer.
// Assumes a register port that returns read data one cycle after bus_rd.
// Delays are in prescaler ticks of TICK_DIV clocks each.
module ata_srst_seq
    import ata_srst_pkg::*;
#(
    parameter int TICK_DIV      = 100,
    parameter int SETTLE_TICKS  = 2000,
    parameter int HOLD_TICKS    = 5,
    parameter int TIMEOUT_TICKS = 32_000_000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    output logic       done,
    output logic       err,
    output logic       bus_rd,
    output logic       bus_wr,
    output logic       bus_ctl_blk,
    output logic [2:0] bus_addr,
    output logic [7:0] bus_wdata,
    input  logic [7:0] bus_rdata
);

    localparam int TW = $clog2(max3(SETTLE_TICKS, HOLD_TICKS, TIMEOUT_TICKS) + 1);

    logic          tick;
    logic          tmr_load;
    logic [TW-1:0] tmr_val;
    logic          tmr_exp;
    logic          unused_status_bits;

    assign unused_status_bits = ^bus_rdata[6:0];

    ata_srst_tick #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tmr_load),
        .tick  (tick)
    );

    ata_srst_timer #(.TW(TW)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .val     (tmr_val),
        .tick    (tick),
        .expired (tmr_exp)
    );

    ata_srst_fsm #(
        .TW            (TW),
        .SETTLE_TICKS  (SETTLE_TICKS),
        .HOLD_TICKS    (HOLD_TICKS),
        .TIMEOUT_TICKS (TIMEOUT_TICKS)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .busy_bit    (bus_rdata[BSY_BIT]),
        .tmr_exp     (tmr_exp),
        .tmr_load    (tmr_load),
        .tmr_val     (tmr_val),
        .bus_rd      (bus_rd),
        .bus_wr      (bus_wr),
        .bus_ctl_blk (bus_ctl_blk),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .done        (done),
        .err         (err)
    );

    AST_IDLE_AFTER_RESET: assert property (@(posedge clk)
        !rst_n |=> (!done && !err && !bus_rd && !bus_wr));  // R1

endmodule

// File: tb/ata_srst_seq_tb.sv
// Bench: directed scenarios against a behavioural device with a busy flag.
module ata_srst_seq_tb;

    localparam int DIV = 4;
    localparam int SET = 10;
    localparam int HLD = 3;
    localparam int TMO = 40;
    localparam int FOREVER = 1_000_000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       done, err, bus_rd, bus_wr, bus_ctl_blk;
    logic [2:0] bus_addr;
    logic [7:0] bus_wdata;
    logic [7:0] bus_rdata = 8'h50;

    int cyc = 0;
    int bsy_until = 0;
    int post_busy = 0;

    int n_chk = 0;
    int n_fail = 0;

    int n_done, n_err, n_wr, n_rd, n_bad_rd, n_bad_wr, n_dbl, n_both;
    int first_rd, first_rd2, done_cyc, err_cyc, start_cyc;
    int wr_cyc [2];
    int wr_dat [2];
    logic prev_done, prev_err;

    always #5 clk = ~clk;

    ata_srst_seq #(
        .TICK_DIV(DIV), .SETTLE_TICKS(SET), .HOLD_TICKS(HLD), .TIMEOUT_TICKS(TMO)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .done(done), .err(err),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_ctl_blk(bus_ctl_blk),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    // Device model: status with busy in bit 7, soft reset raises busy.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (bus_wr && bus_ctl_blk && bus_addr == 3'd2 && bus_wdata[2])
            bsy_until <= cyc + post_busy;
        bus_rdata <= {(cyc < bsy_until), 7'h50};
    end

    task automatic clear_mon();
        n_done = 0; n_err = 0; n_wr = 0; n_rd = 0; n_bad_rd = 0; n_bad_wr = 0;
        n_dbl = 0; n_both = 0; first_rd = -1; first_rd2 = -1;
        done_cyc = -1; err_cyc = -1;
        wr_cyc[0] = -1; wr_cyc[1] = -1; wr_dat[0] = -1; wr_dat[1] = -1;
    endtask

    initial clear_mon();

    // Monitor: sample outputs away from the active edge.
    always @(negedge clk) begin
        if (done) begin n_done++; done_cyc = cyc; end
        if (err)  begin n_err++;  err_cyc  = cyc; end
        if ((done && prev_done) || (err && prev_err)) n_dbl++;
        if (done && err) n_both++;
        if (bus_rd) begin
            if (bus_ctl_blk || bus_addr != 3'd7) n_bad_rd++;
            if (first_rd < 0) first_rd = cyc;
            if (n_wr == 2 && first_rd2 < 0) first_rd2 = cyc;
            n_rd++;
        end
        if (bus_wr) begin
            if (!bus_ctl_blk || bus_addr != 3'd2) n_bad_wr++;
            if (n_wr < 2) begin wr_cyc[n_wr] = cyc; wr_dat[n_wr] = int'(bus_wdata); end
            n_wr++;
        end
        prev_done = done;
        prev_err  = err;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic pulse_start();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic run_seq(input int pre, input int post);
        @(negedge clk);
        post_busy = post;
        bsy_until = cyc + pre;
        clear_mon();
        start = 1'b1;
        start_cyc = cyc;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 2000 && (n_done + n_err) == 0; i++) @(negedge clk);
        repeat (10) @(negedge clk);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        chk(!done && !err, "R1 end pulses low in reset", int'(done) + int'(err), 0);
        chk(!bus_rd && !bus_wr, "R1 no access in reset", int'(bus_rd) + int'(bus_wr), 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk(!done && !err && !bus_rd && !bus_wr, "R1 idle after reset",
            int'(done) + int'(err) + int'(bus_rd) + int'(bus_wr), 0);
    endtask

    task automatic t_clean();
        run_seq(0, 0);
        chk(n_done == 1 && n_err == 0, "R6 done once on clean run", n_done, 1);
        chk(first_rd - start_cyc >= SET*DIV && first_rd - start_cyc <= SET*DIV + 4,
            "R2 pre-settle delay", first_rd - start_cyc, SET*DIV);
        chk(n_wr == 2, "R4 two device control writes", n_wr, 2);
        chk(wr_dat[0] == 8'h0E, "R4 assert value", wr_dat[0], 8'h0E);
        chk(wr_dat[1] == 8'h0A, "R5 release value", wr_dat[1], 8'h0A);
        chk(wr_cyc[1] - wr_cyc[0] >= HLD*DIV && wr_cyc[1] - wr_cyc[0] <= HLD*DIV + 4,
            "R5 hold time", wr_cyc[1] - wr_cyc[0], HLD*DIV);
        chk(first_rd2 - wr_cyc[1] >= SET*DIV && first_rd2 - wr_cyc[1] <= SET*DIV + 4,
            "R6 post-settle delay", first_rd2 - wr_cyc[1], SET*DIV);
        chk(n_bad_rd == 0, "R3 reads hit status", n_bad_rd, 0);
        chk(n_bad_wr == 0, "R4 writes hit device control", n_bad_wr, 0);
        chk(n_dbl == 0 && n_both == 0, "R9 single exclusive pulse", n_dbl + n_both, 0);
    endtask

    task automatic t_busy_pre();
        run_seq(100, 0);
        chk(n_done == 1, "R3 completes after busy clears", n_done, 1);
        chk(wr_cyc[0] - start_cyc >= 100, "R3 no write while busy", wr_cyc[0] - start_cyc, 100);
        chk(n_rd > 2, "R3 status polled repeatedly", n_rd, 3);
    endtask

    task automatic t_tmo_pre();
        run_seq(FOREVER, 0);
        chk(n_err == 1 && n_done == 0, "R7 error on stuck busy before reset", n_err, 1);
        chk(n_wr == 0, "R7 no write after pre timeout", n_wr, 0);
        chk(err_cyc - start_cyc >= (SET + TMO)*DIV && err_cyc - start_cyc <= (SET + TMO)*DIV + 10,
            "R7 timeout length", err_cyc - start_cyc, (SET + TMO)*DIV);
        chk(n_dbl == 0, "R9 err single cycle", n_dbl, 0);
    endtask

    task automatic t_busy_post();
        run_seq(0, 80);
        chk(n_done == 1 && n_err == 0, "R7 recovers to idle and R6 completes", n_done, 1);
        chk(done_cyc - wr_cyc[0] >= 80, "R6 waits for busy after reset", done_cyc - wr_cyc[0], 80);
    endtask

    task automatic t_tmo_post();
        run_seq(0, FOREVER);
        chk(n_err == 1 && n_done == 0, "R7 error on stuck busy after reset", n_err, 1);
        chk(n_wr == 2, "R7 writes before post timeout only", n_wr, 2);
    endtask

    task automatic t_restart();
        @(negedge clk);
        post_busy = 0;
        bsy_until = cyc;
        clear_mon();
        start = 1'b1;
        start_cyc = cyc;
        @(negedge clk);
        start = 1'b0;
        repeat (15) @(negedge clk);
        pulse_start();
        for (int i = 0; i < 500 && n_wr == 0; i++) @(negedge clk);
        pulse_start();
        for (int i = 0; i < 2000 && (n_done + n_err) == 0; i++) @(negedge clk);
        repeat (10) @(negedge clk);
        chk(n_done == 1 && n_err == 0, "R8 one completion despite extra start", n_done, 1);
        chk(n_wr == 2, "R8 no extra writes", n_wr, 2);
        chk(first_rd - start_cyc <= SET*DIV + 4, "R8 timing not restarted",
            first_rd - start_cyc, SET*DIV);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        summary();
        $finish;
    end

    initial begin
        t_reset();
        t_clean();
        t_busy_pre();
        t_tmo_pre();
        t_busy_post();
        t_tmo_post();
        t_restart();
        summary();
        $finish;
    end

endmodule